// File: doc/BRIEF.md
# Audio serial clock generator

This block produces the three controller-side clocks of an audio serial link from the system clock. A master clock and a bit clock each come from their own integer divider. A word clock is derived by counting bit-clock periods. The word clock can be framed two ways. In the two-phase form it is high for half the frame and low for the other half. In the one-phase form it carries a single bit-clock-wide pulse at the start of each frame.

A source select lets the word and bit clock outputs follow externally supplied clocks instead of the internal dividers. A polarity bit can invert the word clock in either source mode. The master clock has its own enable. The word and bit clocks share a second enable. Outputs are combinational decodes of registered counters and are meant to be retimed or used as clock enables by the consumer.

Top module: `audio_clkgen`

## Requirements
- R1: The master clock period is `mclk_div` system cycles, with a value of 0 meaning 1024. Each period starts with floor(ratio/2) high cycles, followed by low cycles for the rest of the period.
- R2: The bit clock period is `bclk_div` system cycles, with a value of 0 meaning 1024. Its high part uses the same floor(ratio/2) rule as R1.
- R3: With `dual_phase`=1 and internal source, the word clock is high for `wclk_div` bit periods and low for `wclk_div` bit periods. It changes level only where a bit period begins.
- R4: With `dual_phase`=0 and internal source, the frame lasts `wclk_div`+1 bit periods. The word clock is high only during the first of them.
- R5: With `wclk_inv`=1 the word clock output is the complement of its non-inverted level whenever `wbclk_en` is 1.
- R6: With `src_int`=0, `bclk_o` equals `ext_bclk` and `wclk_o` equals `ext_wclk` XOR `wclk_inv` while `wbclk_en` is 1.
- R7: A deasserted enable holds its outputs low and restarts its counters. The first enabled cycle therefore shows the output high, and `mclk_en` and `wbclk_en` act independently of each other.
- R8: A new divider value is taken only when the running period ends, so the period in progress completes with the old ratio.
- R9: After reset, with both enables low, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_en | input | 1 | Master clock enable |
| wbclk_en | input | 1 | Shared word/bit clock enable |
| src_int | input | 1 | 1: internal dividers, 0: external clocks |
| dual_phase | input | 1 | 1: two-phase word clock, 0: one-phase pulse |
| wclk_inv | input | 1 | Invert word clock polarity |
| mclk_div | input | DIV_W | Master clock ratio, 0 = 1024 |
| bclk_div | input | DIV_W | Bit clock ratio, 0 = 1024 |
| wclk_div | input | DIV_W | Word clock divide value in bit periods |
| ext_bclk | input | 1 | External bit clock |
| ext_wclk | input | 1 | External word clock |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock |

## Verification
The assertions assume that ratios stay within their legal ranges: 2 to 1024 for the master and bit dividers, and at least 1 for the word divide value. They also assume the enables are known from reset onward. The stimulus programs only legal ratios and drives every input from time zero. It changes dividers and enables only at falling system-clock edges, so that each registered update is seen on a clean rising edge.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  // ratio encoded by a divider field; zero selects the largest ratio
  function automatic int unsigned ratio_of(input int unsigned v, input int unsigned maxr);
    return (v == 0) ? maxr : v;
  endfunction

  // frame length in bit periods for a word divide value and framing mode
  function automatic int unsigned frame_len(input int unsigned w, input bit dual);
    if (dual) return (w == 0) ? 1 : 2 * w;
    return w + 1;
  endfunction
endpackage

// File: rtl/aclk_div.sv
module aclk_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             out,
  output logic             wrap
);
  import aclk_pkg::*;
  localparam int RW   = DIV_W + 1;
  localparam int MAXR = 1 << DIV_W;

  logic [RW-1:0] act, cnt, want;
  logic          tc;

  assign want = RW'(ratio_of(32'(div), MAXR));
  assign tc   = (cnt == act - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= RW'(2);
    end else if (!en) begin
      cnt <= '0;
      act <= want;
    end else if (tc) begin
      cnt <= '0;
      act <= want;
    end else begin
      cnt <= cnt + RW'(1);
    end
  end

  assign out  = en & (cnt < (act >> 1));
  assign wrap = en & tc;

  // a new ratio is adopted only at the end of a period
  assert_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && act != $past(act)) |-> $past(tc));
  // a fresh enable starts on a high phase
  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> out);
  // rising output only after a completed period
  assert_duty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $rose(out)) |-> $past(tc));
endmodule

// File: rtl/aclk_word.sv
module aclk_word #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             btick,
  input  logic             dual,
  input  logic [DIV_W-1:0] wdiv,
  output logic             level
);
  import aclk_pkg::*;
  localparam int FW = DIV_W + 2;

  logic [FW-1:0] wact, fl, cnt;
  logic          dual_q, last;

  assign fl   = FW'(frame_len(32'(wact), dual_q));
  assign last = (cnt == fl - FW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      wact   <= FW'(1);
      dual_q <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      wact   <= FW'(wdiv);
      dual_q <= dual;
    end else if (btick) begin
      if (last) begin
        cnt    <= '0;
        wact   <= FW'(wdiv);
        dual_q <= dual;
      end else begin
        cnt <= cnt + FW'(1);
      end
    end
  end

  assign level = en & (dual_q ? (cnt < wact) : (cnt == '0));

  // word level moves only where a bit period begins
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && level != $past(level)) |-> $past(btick));
  // framing settings change only on a frame boundary
  assert_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && wact != $past(wact)) |-> $past(btick && last));
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclk_en,
  input  logic             wbclk_en,
  input  logic             src_int,
  input  logic             dual_phase,
  input  logic             wclk_inv,
  input  logic [DIV_W-1:0] mclk_div,
  input  logic [DIV_W-1:0] bclk_div,
  input  logic [DIV_W-1:0] wclk_div,
  input  logic             ext_bclk,
  input  logic             ext_wclk,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             wclk_o
);
  logic int_en, m_wrap, b_wrap, bclk_int, wlevel;

  assign int_en = wbclk_en & src_int;

  aclk_div #(.DIV_W(DIV_W)) u_mdiv (
    .clk(clk), .rst_n(rst_n), .en(mclk_en), .div(mclk_div),
    .out(mclk_o), .wrap(m_wrap));

  aclk_div #(.DIV_W(DIV_W)) u_bdiv (
    .clk(clk), .rst_n(rst_n), .en(int_en), .div(bclk_div),
    .out(bclk_int), .wrap(b_wrap));

  aclk_word #(.DIV_W(DIV_W)) u_word (
    .clk(clk), .rst_n(rst_n), .en(int_en), .btick(b_wrap),
    .dual(dual_phase), .wdiv(wclk_div), .level(wlevel));

  assign bclk_o = wbclk_en & (src_int ? bclk_int : ext_bclk);
  assign wclk_o = wbclk_en & ((src_int ? wlevel : ext_wclk) ^ wclk_inv);

  // master clock re-enters its high phase right after each period end
  assert_mper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_en && $past(mclk_en) && $past(m_wrap)) |-> mclk_o);
endmodule

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;
  localparam int DW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mclk_en = 0, wbclk_en = 0, src_int = 1, dual_phase = 0, wclk_inv = 0;
  logic [DW-1:0] mclk_div = 2, bclk_div = 2, wclk_div = 1;
  logic ext_bclk = 0, ext_wclk = 0;
  logic mclk_o, bclk_o, wclk_o;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  audio_clkgen #(.DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .wbclk_en(wbclk_en),
    .src_int(src_int), .dual_phase(dual_phase), .wclk_inv(wclk_inv),
    .mclk_div(mclk_div), .bclk_div(bclk_div), .wclk_div(wclk_div),
    .ext_bclk(ext_bclk), .ext_wclk(ext_wclk),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .wclk_o(wclk_o));

  // {mclk_div, bclk_div, wclk_div, dual_phase}
  localparam int VEC [4][4] = '{
    '{2, 2, 3, 0}, '{7, 4, 4, 1}, '{0, 3, 2, 1}, '{3, 0, 1, 0}};

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit sig(input int sel);
    return (sel == 0) ? mclk_o : (sel == 1) ? bclk_o : wclk_o;
  endfunction

  task automatic wait_rise(input int sel);
    int g = 0;
    @(negedge clk);
    while (sig(sel) && g < 20000) begin @(negedge clk); g++; end
    while (!sig(sel) && g < 20000) begin @(negedge clk); g++; end
  endtask

  task automatic count_period(input int sel, output int hi, output int per);
    hi = 0; per = 0;
    while (sig(sel) && per < 20000) begin hi++; per++; @(negedge clk); end
    while (!sig(sel) && per < 20000) begin per++; @(negedge clk); end
  endtask

  task automatic measure(input int sel, output int hi, output int per);
    wait_rise(sel);
    count_period(sel, hi, per);
  endtask

  initial begin
    #(20 * 190000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hi, per, mr, br, w, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: idle after reset
    chk("R9 mclk", mclk_o, 0); chk("R9 bclk", bclk_o, 0); chk("R9 wclk", wclk_o, 0);

    foreach (VEC[i]) begin
      mclk_en = 0; wbclk_en = 0;
      mclk_div = DW'(VEC[i][0]); bclk_div = DW'(VEC[i][1]);
      wclk_div = DW'(VEC[i][2]); dual_phase = VEC[i][3][0];
      @(negedge clk);
      mclk_en = 1; wbclk_en = 1;
      mr = (VEC[i][0] == 0) ? 1024 : VEC[i][0];
      br = (VEC[i][1] == 0) ? 1024 : VEC[i][1];
      w = VEC[i][2]; d = VEC[i][3];
      measure(0, hi, per); chk("R1 mclk high", hi, mr / 2); chk("R1 mclk period", per, mr);
      measure(1, hi, per); chk("R2 bclk high", hi, br / 2); chk("R2 bclk period", per, br);
      measure(2, hi, per);
      if (d != 0) begin
        chk("R3 wclk high", hi, br * w); chk("R3 wclk period", per, br * 2 * w);
      end else begin
        chk("R4 wclk high", hi, br); chk("R4 wclk period", per, br * (w + 1));
      end
    end

    // R5: inverted one-phase word clock
    wbclk_en = 0; bclk_div = 2; wclk_div = 3; dual_phase = 0; wclk_inv = 1;
    @(negedge clk); #1;
    chk("R5 low while disabled", wclk_o, 0);
    @(negedge clk); wbclk_en = 1;
    measure(2, hi, per); chk("R5 inv high", hi, 6); chk("R5 inv period", per, 8);

    // R6: external source pass-through
    @(negedge clk); src_int = 0; ext_bclk = 1; ext_wclk = 0; wclk_inv = 1; #1;
    chk("R6 bclk ext", bclk_o, 1); chk("R6 wclk ext inv", wclk_o, 1);
    ext_bclk = 0; ext_wclk = 1; wclk_inv = 0; #1;
    chk("R6 bclk ext low", bclk_o, 0); chk("R6 wclk ext", wclk_o, 1);
    wbclk_en = 0; #1;
    chk("R7 ext gated", wclk_o, 0);
    src_int = 1;

    // R7: independent enables, hold low, restart high
    @(negedge clk); wbclk_en = 0; mclk_en = 1; mclk_div = 5;
    hi = 0;
    repeat (12) begin @(negedge clk); hi += bclk_o + wclk_o; end
    chk("R7 bclk/wclk stay low with only mclk_en", hi, 0);
    mclk_en = 0;
    hi = 0;
    repeat (6) begin @(negedge clk); hi += mclk_o; end
    chk("R7 mclk held low", hi, 0);
    mclk_en = 1; #1;
    chk("R7 restart high", mclk_o, 1);

    // R8: change ratio mid-period
    mclk_en = 0; mclk_div = 8; @(negedge clk); mclk_en = 1;
    wait_rise(0);
    mclk_div = 2;
    count_period(0, hi, per); chk("R8 old high", hi, 4); chk("R8 old period", per, 8);
    count_period(0, hi, per); chk("R8 new period", per, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule